// File: doc/BRIEF.md
# Spike-Timing Plasticity Queue Engine

This block applies a spike-timing learning rule to a signed synaptic weight memory that it does not own. It keeps two short histories of recent spikes, one for input (presynaptic) neurons and one for output (postsynaptic) neurons. Each stored spike carries the neuron's identifier and a timing value. The timing value starts at a window constant and counts down by one on every time tick until it reaches zero. No timestamps are stored.

When an output neuron fires, the engine walks the input history from the newest entry to the oldest. For each live entry it raises the weight of the synapse from that input to the firing output. When an input neuron fires, it walks the output history in the same order and lowers the weight of each synapse from the firing input to each recently active output. The size of each step is the entry's timing value shifted right by a fixed amount. Every weight change is a read-modify-write through an external port with one cycle of read latency. The written value saturates at fixed limits. The depression window is configured longer than the potentiation window, so the rule is biased toward weakening.

An event router feeds spike identifiers in on single-cycle strobes. A global tick input sets the time step. `busy` stays high while an event is waiting or being processed.

Top module: `stdp_queue_engine`

## Requirements
- R1: Synchronous reset clears both histories. After reset, `busy`, `wt_rd_en` and `wt_wr_en` are low. A spike arriving on an empty opposite history causes no weight access.
- R2: A new input-history entry starts at TAU_PLUS (6) and a new output-history entry starts at TAU_MINUS (9), where TAU_MINUS > TAU_PLUS. The weight step is the timing value shifted right by ETA_SHIFT (1).
- R3: Each cycle with `tick` high lowers every stored timing value by one, stopping at zero. An entry written in the same cycle is not lowered.
- R4: An output spike on neuron y raises the weight at (`wt_pre_id`=x, `wt_post_id`=y) once for each live input entry x. Entries are visited newest first, with one write per live entry.
- R5: An input spike on neuron x lowers the weight at (x, y) once for each live output entry y. Entries are visited newest first, with one write per live entry.
- R6: An entry whose timing value is zero changes no weight, and the walk ends at the first such entry.
- R7: Each history holds Q_DEPTH (4) entries. A new entry into a full history replaces the oldest one, so only the newest Q_DEPTH spikes of a kind can pair.
- R8: A written weight never leaves [W_MIN, W_MAX] = [-100, 100]. A step that would cross a limit writes the limit instead.
- R9: A spike arriving while another is processed is held and processed afterwards. A waiting output spike is served before a waiting input spike. A spike enters its own history only after its own walk ends.
- R10: Each weight update raises `wt_rd_en` for one cycle and `wt_wr_en` in the next cycle with the same identifiers, using `wt_rd_data` from that next cycle. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One time step of decay |
| pre_spike | input | 1 | Input neuron spike strobe |
| pre_id | input | ADDR_W | Identifier of the firing input neuron |
| post_spike | input | 1 | Output neuron spike strobe |
| post_id | input | ADDR_W | Identifier of the firing output neuron |
| busy | output | 1 | Event waiting or being processed |
| wt_rd_en | output | 1 | Weight read strobe |
| wt_wr_en | output | 1 | Weight write strobe |
| wt_pre_id | output | ADDR_W | Input-neuron part of the synapse location |
| wt_post_id | output | ADDR_W | Output-neuron part of the synapse location |
| wt_rd_data | input | W_W | Signed weight, valid the cycle after `wt_rd_en` |
| wt_wr_data | output | W_W | Signed updated weight |

## Verification
Single causal pairs are swept over every tick gap from zero to past the potentiation window, and single anti-causal pairs over every gap past the depression window. These sweeps separate the two window lengths, the shift and the cut-off at zero. Entries of mixed age, and bursts longer than the history, show where the walk stops and which entry is dropped. Long runs of repeated pairings push a weight against each limit. Simultaneous spikes, and a spike landing in the middle of another walk, show the service order and confirm that a spike does not pair before it is stored.

// File: rtl/stdp_pkg.sv
// Shared types and helpers for the plasticity queue engine.
// Assumes history depths small enough for int arithmetic on indices.
package stdp_pkg;

    // Walk sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_INSERT
    } scan_state_e;

    // Circular index `back` slots behind `base`, for a ring of `depth` slots
    function automatic int unsigned ring_back(int unsigned base, int unsigned back,
                                              int unsigned depth);
        return (base + 2 * depth - back) % depth;
    endfunction

endpackage

// File: rtl/stdp_event_queue.sv
// Spike history ring: neuron identifier plus a decaying timing value per slot.
// New entries start at TAU. Every tick lowers all values, stopping at zero.
// A full ring overwrites its oldest slot, and one expired tail entry is
// dropped per cycle. Lookup is by distance from the newest entry.
// Assumes TAU fits in TV_W bits and DEPTH >= 2.
module stdp_event_queue #(
    parameter int ADDR_W = 3,
    parameter int DEPTH  = 4,
    parameter int TV_W   = 4,
    parameter int TAU    = 6,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [CW-1:0]     rd_k,
    output logic              rd_live,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TV_W-1:0]   rd_tv
);
    import stdp_pkg::*;

    localparam int PW = $clog2(DEPTH);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [TV_W-1:0]   tv_q   [DEPTH];
    logic [PW-1:0]     head;
    logic [CW-1:0]     cnt;
    logic [PW-1:0]     rd_ix, old_ix, new_ix;
    logic              in_range, full_push, prune;

    // Slot addressing relative to the write pointer
    always_comb begin
        rd_ix  = PW'(ring_back(int'(head), int'(rd_k) + 1, DEPTH));
        old_ix = PW'(ring_back(int'(head), int'(cnt), DEPTH));
        new_ix = PW'(ring_back(int'(head), 1, DEPTH));
    end

    // Lookup of the k-th newest entry; out-of-range reads as expired
    always_comb begin
        in_range = (rd_k < cnt);
        rd_addr  = addr_q[rd_ix];
        rd_tv    = in_range ? tv_q[rd_ix] : '0;
        rd_live  = in_range && (tv_q[rd_ix] != '0);
    end

    // Occupancy bookkeeping: overwrite when full, drop an expired tail
    always_comb begin
        full_push = push && (cnt == CW'(DEPTH));
        prune     = (cnt != '0) && (tv_q[old_ix] == '0) && !full_push;
    end

    // Slot contents: load on push, decay on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                tv_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && (PW'(i) == head)) begin
                    addr_q[i] <= push_addr;
                    tv_q[i]   <= TV_W'(TAU);
                end else if (tick && (tv_q[i] != '0)) begin
                    tv_q[i] <= tv_q[i] - 1'b1;
                end
            end
        end
    end

    // Write pointer and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                head <= (head == PW'(DEPTH - 1)) ? '0 : head + 1'b1;
            end
            if (push && !full_push && !prune) begin
                cnt <= cnt + 1'b1;
            end else if (!push && prune) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R2
    push_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (tv_q[new_ix] == TV_W'(TAU)));

    // R3
    decay_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !push && $past(rst_n)) |=>
            (tv_q[new_ix] == (($past(tv_q[new_ix]) == '0) ? '0
                                                          : $past(tv_q[new_ix]) - 1'b1)));

endmodule

// File: rtl/stdp_scan_ctrl.sv
// Event sequencer. Holds one waiting spike per kind, serves output spikes
// before input spikes, walks the opposite history newest first, issues a
// read then a write per live entry, and stores the spike in its own
// history when its walk ends. Assumes weight read data arrives one cycle
// after the read strobe.
module stdp_scan_ctrl #(
    parameter int ADDR_W = 3,
    parameter int CW     = 3,
    parameter int TV_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_spike,
    input  logic [ADDR_W-1:0] pre_id,
    input  logic              post_spike,
    input  logic [ADDR_W-1:0] post_id,
    input  logic              q_live,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [TV_W-1:0]   q_tv,
    output logic [CW-1:0]     rd_k,
    output logic              scan_post,
    output logic              ins_en,
    output logic [ADDR_W-1:0] ins_addr,
    output logic              busy,
    output logic              wt_rd_en,
    output logic              wt_wr_en,
    output logic [ADDR_W-1:0] wt_pre_id,
    output logic [ADDR_W-1:0] wt_post_id,
    output logic [TV_W-1:0]   upd_tv
);
    import stdp_pkg::*;

    scan_state_e       state;
    logic              pend_pre, pend_post;
    logic [ADDR_W-1:0] pend_pre_id, pend_post_id;
    logic [ADDR_W-1:0] cur_id;
    logic              take_post, take_pre;

    // Service choice: output spikes win over input spikes
    always_comb begin
        take_post = (state == ST_IDLE) && pend_post;
        take_pre  = (state == ST_IDLE) && !pend_post && pend_pre;
    end

    // Waiting-spike holders; a fresh arrival overrides a same-cycle take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pre     <= 1'b0;
            pend_post    <= 1'b0;
            pend_pre_id  <= '0;
            pend_post_id <= '0;
        end else begin
            if (take_pre)  pend_pre  <= 1'b0;
            if (take_post) pend_post <= 1'b0;
            if (pre_spike) begin
                pend_pre    <= 1'b1;
                pend_pre_id <= pre_id;
            end
            if (post_spike) begin
                pend_post    <= 1'b1;
                pend_post_id <= post_id;
            end
        end
    end

    // Walk sequencer: check entry, read weight, write weight, then store spike
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            scan_post  <= 1'b0;
            cur_id     <= '0;
            rd_k       <= '0;
            wt_pre_id  <= '0;
            wt_post_id <= '0;
            upd_tv     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    rd_k <= '0;
                    if (take_post) begin
                        scan_post <= 1'b1;
                        cur_id    <= pend_post_id;
                        state     <= ST_CHECK;
                    end else if (take_pre) begin
                        scan_post <= 1'b0;
                        cur_id    <= pend_pre_id;
                        state     <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (q_live) begin
                        wt_pre_id  <= scan_post ? q_addr : cur_id;
                        wt_post_id <= scan_post ? cur_id : q_addr;
                        upd_tv     <= q_tv;
                        state      <= ST_READ;
                    end else begin
                        state <= ST_INSERT;
                    end
                end
                ST_READ:   state <= ST_WRITE;
                ST_WRITE: begin
                    rd_k  <= rd_k + 1'b1;
                    state <= ST_CHECK;
                end
                ST_INSERT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Strobes decoded from the sequencer state
    always_comb begin
        wt_rd_en = (state == ST_READ);
        wt_wr_en = (state == ST_WRITE);
        ins_en   = (state == ST_INSERT);
        ins_addr = cur_id;
        busy     = (state != ST_IDLE) || pend_pre || pend_post;
    end

    // R9
    insert_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !q_live);

    // R9
    spike_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spike || post_spike) |=> busy);

endmodule

// File: rtl/stdp_weight_calc.sv
// Combinational weight step: timing value shifted right by ETA_SHIFT,
// added or subtracted, then clamped to [W_MIN, W_MAX].
// Assumes W_MIN < 0 < W_MAX and that both limits fit in W_W signed bits.
module stdp_weight_calc #(
    parameter int W_W       = 8,
    parameter int TV_W      = 4,
    parameter int ETA_SHIFT = 1,
    parameter int W_MAX     = 100,
    parameter int W_MIN     = -100
) (
    input  logic signed [W_W-1:0] old_w,
    input  logic [TV_W-1:0]       tv,
    input  logic                  raise,
    output logic signed [W_W-1:0] new_w
);
    localparam int SW = ((W_W > TV_W) ? W_W : TV_W) + 2;
    localparam logic signed [SW-1:0] HI = SW'(W_MAX);
    localparam logic signed [SW-1:0] LO = SW'(W_MIN);

    logic [TV_W-1:0]        step_u;
    logic signed [SW-1:0]   step_s, old_s, sum;

    // Widened signed step and sum, then clamp
    always_comb begin
        step_u = tv >> ETA_SHIFT;
        step_s = $signed({{(SW - TV_W){1'b0}}, step_u});
        old_s  = SW'(old_w);
        sum    = raise ? (old_s + step_s) : (old_s - step_s);
        if (sum > HI) begin
            new_w = W_W'(HI);
        end else if (sum < LO) begin
            new_w = W_W'(LO);
        end else begin
            new_w = W_W'(sum);
        end
    end

endmodule

// File: rtl/stdp_queue_engine.sv
// Top of the plasticity queue engine. Two history rings (input spikes with
// window TAU_PLUS, output spikes with window TAU_MINUS) feed one sequencer
// that updates an external signed weight memory by read-modify-write.
// Assumes TAU_MINUS > TAU_PLUS, ticks arriving while the engine is idle,
// and one-cycle read latency on the weight memory.
module stdp_queue_engine
    import stdp_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int Q_DEPTH   = 4,
    parameter int TV_W      = 4,
    parameter int TAU_PLUS  = 6,
    parameter int TAU_MINUS = 9,
    parameter int ETA_SHIFT = 1,
    parameter int W_W       = 8,
    parameter int W_MAX     = 100,
    parameter int W_MIN     = -100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  pre_spike,
    input  logic [ADDR_W-1:0]     pre_id,
    input  logic                  post_spike,
    input  logic [ADDR_W-1:0]     post_id,
    output logic                  busy,
    output logic                  wt_rd_en,
    output logic                  wt_wr_en,
    output logic [ADDR_W-1:0]     wt_pre_id,
    output logic [ADDR_W-1:0]     wt_post_id,
    input  logic signed [W_W-1:0] wt_rd_data,
    output logic signed [W_W-1:0] wt_wr_data
);
    localparam int CW = $clog2(Q_DEPTH + 1);

    logic [CW-1:0]     rd_k;
    logic              scan_post, ins_en;
    logic [ADDR_W-1:0] ins_addr;
    logic [TV_W-1:0]   upd_tv;
    logic              q_live_a [2];
    logic [ADDR_W-1:0] q_addr_a [2];
    logic [TV_W-1:0]   q_tv_a   [2];
    logic              sel_live;
    logic [ADDR_W-1:0] sel_addr;
    logic [TV_W-1:0]   sel_tv;

    // History rings: index 0 holds input spikes, index 1 output spikes
    for (genvar g = 0; g < 2; g++) begin : g_hist
        localparam int TAU_G = (g == 0) ? TAU_PLUS : TAU_MINUS;
        logic push_g;
        assign push_g = ins_en && (scan_post == (g == 1));
        stdp_event_queue #(
            .ADDR_W(ADDR_W),
            .DEPTH (Q_DEPTH),
            .TV_W  (TV_W),
            .TAU   (TAU_G)
        ) u_hist (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .push     (push_g),
            .push_addr(ins_addr),
            .rd_k     (rd_k),
            .rd_live  (q_live_a[g]),
            .rd_addr  (q_addr_a[g]),
            .rd_tv    (q_tv_a[g])
        );
    end

    // An output spike walks the input ring; an input spike walks the output ring
    always_comb begin
        sel_live = scan_post ? q_live_a[0] : q_live_a[1];
        sel_addr = scan_post ? q_addr_a[0] : q_addr_a[1];
        sel_tv   = scan_post ? q_tv_a[0]   : q_tv_a[1];
    end

    stdp_scan_ctrl #(
        .ADDR_W(ADDR_W),
        .CW    (CW),
        .TV_W  (TV_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_spike (pre_spike),
        .pre_id    (pre_id),
        .post_spike(post_spike),
        .post_id   (post_id),
        .q_live    (sel_live),
        .q_addr    (sel_addr),
        .q_tv      (sel_tv),
        .rd_k      (rd_k),
        .scan_post (scan_post),
        .ins_en    (ins_en),
        .ins_addr  (ins_addr),
        .busy      (busy),
        .wt_rd_en  (wt_rd_en),
        .wt_wr_en  (wt_wr_en),
        .wt_pre_id (wt_pre_id),
        .wt_post_id(wt_post_id),
        .upd_tv    (upd_tv)
    );

    stdp_weight_calc #(
        .W_W      (W_W),
        .TV_W     (TV_W),
        .ETA_SHIFT(ETA_SHIFT),
        .W_MAX    (W_MAX),
        .W_MIN    (W_MIN)
    ) u_calc (
        .old_w(wt_rd_data),
        .tv   (upd_tv),
        .raise(scan_post),
        .new_w(wt_wr_data)
    );

    // R8
    sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wt_wr_en |-> ((wt_wr_data <= W_MAX) && (wt_wr_data >= W_MIN)));

    // R4
    raise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_wr_en && scan_post && (wt_rd_data <= W_MAX)) |-> (wt_wr_data >= wt_rd_data));

    // R5
    lower_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_wr_en && !scan_post && (wt_rd_data >= W_MIN)) |-> (wt_wr_data <= wt_rd_data));

    // R10
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_wr_en && $past(rst_n)) |->
            ($past(wt_rd_en) && $stable(wt_pre_id) && $stable(wt_post_id)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wt_rd_en && wt_wr_en));

endmodule

// File: tb/stdp_queue_engine_tb.sv
// Self-checking bench: models the weight memory and predicts every weight
// from the spike history and tick count.
module stdp_queue_engine_tb;
    localparam int AW = 3, DEPTH = 4, TVW = 4, TAU_P = 6, TAU_M = 9;
    localparam int ETA = 1, WW = 8, WMAX = 100, WMIN = -100, NSYN = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, tick = 1'b0, pre_spike = 1'b0, post_spike = 1'b0;
    logic [AW-1:0] pre_id = '0, post_id = '0;
    logic busy, wt_rd_en, wt_wr_en;
    logic [AW-1:0] wt_pre_id, wt_post_id;
    logic signed [WW-1:0] wt_rd_data, wt_wr_data;

    stdp_queue_engine u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .pre_spike(pre_spike), .pre_id(pre_id),
        .post_spike(post_spike), .post_id(post_id),
        .busy(busy), .wt_rd_en(wt_rd_en), .wt_wr_en(wt_wr_en),
        .wt_pre_id(wt_pre_id), .wt_post_id(wt_post_id),
        .wt_rd_data(wt_rd_data), .wt_wr_data(wt_wr_data)
    );

    // Bench-owned weight memory, one cycle read latency
    logic signed [WW-1:0] mem [NSYN];
    logic signed [WW-1:0] rd_q;
    assign wt_rd_data = rd_q;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSYN; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            if (wt_rd_en) rd_q <= mem[{wt_pre_id, wt_post_id}];
            if (wt_wr_en) mem[{wt_pre_id, wt_post_id}] <= wt_wr_data;
        end
    end

    int n_chk = 0, n_fail = 0, wr_cnt = 0, exp_wr = 0, now_t = 0;
    int model_w [NSYN];
    int pre_t [1024], pre_a [1024], post_t [1024], post_a [1024];
    int n_pre = 0, n_post = 0;
    bit done = 0;

    always @(posedge clk) if (rst_n && wt_wr_en) wr_cnt <= wr_cnt + 1;

    // R10 monitor: write follows a read of the same location by one cycle
    logic prev_rd = 1'b0;
    logic [AW-1:0] prev_pre = '0, prev_post = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (wt_wr_en) begin
                n_chk++;
                if (!(prev_rd && prev_pre == wt_pre_id && prev_post == wt_post_id)) begin
                    n_fail++;
                    $display("FAIL R10 write at (%0d,%0d) prev_rd=%0d prev=(%0d,%0d) expected read of same location one cycle earlier",
                             wt_pre_id, wt_post_id, prev_rd, prev_pre, prev_post);
                end
            end
            if (wt_rd_en && wt_wr_en) begin
                n_chk++; n_fail++;
                $display("FAIL R10 rd_en=1 wr_en=1 expected not both");
            end
        end
        prev_rd = wt_rd_en; prev_pre = wt_pre_id; prev_post = wt_post_id;
    end

    function automatic int sat(int v);
        if (v > WMAX) return WMAX;
        if (v < WMIN) return WMIN;
        return v;
    endfunction

    // Model: output spike y walks the newest input entries
    task automatic model_post(int y);
        for (int j = n_pre - 1; j >= 0 && j >= n_pre - DEPTH; j--) begin
            int tv;
            tv = TAU_P - (now_t - pre_t[j]);
            if (tv <= 0) break;
            model_w[pre_a[j] * 8 + y] = sat(model_w[pre_a[j] * 8 + y] + (tv >> ETA));
            exp_wr++;
        end
        post_t[n_post] = now_t; post_a[n_post] = y; n_post++;
    endtask

    // Model: input spike x walks the newest output entries
    task automatic model_pre(int x);
        for (int j = n_post - 1; j >= 0 && j >= n_post - DEPTH; j--) begin
            int tv;
            tv = TAU_M - (now_t - post_t[j]);
            if (tv <= 0) break;
            model_w[x * 8 + post_a[j]] = sat(model_w[x * 8 + post_a[j]] - (tv >> ETA));
            exp_wr++;
        end
        pre_t[n_pre] = now_t; pre_a[n_pre] = x; n_pre++;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Drive spikes in one cycle; the model serves output spikes first
    task automatic fire(bit p, int pa, bit q, int qa);
        @(negedge clk);
        pre_spike = p; pre_id = AW'(pa); post_spike = q; post_id = AW'(qa);
        @(negedge clk);
        pre_spike = 1'b0; post_spike = 1'b0;
        while (busy) @(negedge clk);
        if (q) model_post(qa);
        if (p) model_pre(pa);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            now_t++;
        end
    endtask

    // Compare write count and every weight against the model
    task automatic check_all(string tag, int base);
        n_chk++;
        if (wr_cnt - base != exp_wr) begin
            n_fail++;
            $display("FAIL %s write count actual=%0d expected=%0d", tag, wr_cnt - base, exp_wr);
        end
        n_chk++;
        for (int i = 0; i < NSYN; i++) begin
            if (int'(mem[i]) != model_w[i]) begin
                n_fail++;
                $display("FAIL %s weight[%0d] actual=%0d expected=%0d", tag, i, mem[i], model_w[i]);
                break;
            end
        end
        exp_wr = 0;
    endtask

    task automatic chk_bit(string tag, logic act, logic expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    initial begin
        int base;
        for (int i = 0; i < NSYN; i++) model_w[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_bit("R1 busy after reset", busy, 1'b0);
        chk_bit("R1 rd_en after reset", wt_rd_en, 1'b0);
        chk_bit("R1 wr_en after reset", wt_wr_en, 1'b0);
        base = wr_cnt; fire(0, 0, 1, 2); check_all("R1 output spike on empty history", base);
        base = wr_cnt; fire(1, 5, 0, 0); check_all("R1 input spike on empty history", base);
        ticks(12);

        // R4 R3 R2 causal sweep over tick gaps, past the window (R6)
        for (int a = 0; a <= 7; a++) begin
            fire(1, a, 0, 0);
            ticks(a);
            base = wr_cnt; fire(0, 0, 1, (a + 3) % 8);
            check_all($sformatf("R4/R3/R2 causal gap %0d", a), base);
            ticks(12);
        end

        // R5 R3 R2 anti-causal sweep over tick gaps, past the window (R6)
        for (int a = 0; a <= 10; a++) begin
            fire(0, 0, 1, a % 8);
            ticks(a);
            base = wr_cnt; fire(1, (a + 5) % 8, 0, 0);
            check_all($sformatf("R5/R3/R2 anti-causal gap %0d", a), base);
            ticks(12);
        end

        // R6 mixed ages: the older entry has expired
        fire(1, 1, 0, 0); ticks(3);
        fire(1, 2, 0, 0); ticks(4);
        base = wr_cnt; fire(0, 0, 1, 4); check_all("R6 walk ends at expired entry", base);
        ticks(12);

        // R7 burst longer than the ring
        for (int i = 0; i < 6; i++) fire(1, i, 0, 0);
        base = wr_cnt; fire(0, 0, 1, 7); check_all("R7 only newest entries pair", base);
        ticks(12);

        // R8 upper limit: four inputs, repeated output spikes
        for (int i = 0; i < 4; i++) fire(1, i, 0, 0);
        for (int r = 0; r < 40; r++) begin
            base = wr_cnt; fire(0, 0, 1, 2); check_all("R8 upper saturation", base);
        end
        ticks(12);

        // R8 lower limit: one output, repeated input spikes
        fire(0, 0, 1, 5);
        for (int r = 0; r < 30; r++) begin
            base = wr_cnt; fire(1, 6, 0, 0); check_all("R8 lower saturation", base);
        end
        ticks(12);

        // R9 simultaneous spikes: output served first
        base = wr_cnt; fire(1, 3, 1, 4); check_all("R9 simultaneous spikes", base);
        ticks(12);

        // R9 spike arriving during another walk
        fire(0, 0, 1, 1); fire(0, 0, 1, 2);
        base = wr_cnt;
        @(negedge clk); pre_spike = 1'b1; pre_id = 3'd0;
        @(negedge clk); pre_spike = 1'b0;
        @(negedge clk); post_spike = 1'b1; post_id = 3'd6;
        @(negedge clk); post_spike = 1'b0;
        chk_bit("R9 busy during held spike", busy, 1'b1);
        wait_idle();
        model_pre(0); model_post(6);
        check_all("R9 spike held during walk", base);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule